// File: doc/BRIEF.md
# Weight-Stationary Systolic Convolution Array

This block computes a sliding dot product over a sample stream. For each window that starts at sample x_i it produces y_i = c_0·x_i + c_1·x_{i+1} + … + c_{K-1}·x_{i+K-1}, where the K coefficients are loaded beforehand through a small write port. The work is spread over a row of K multiply-accumulate cells. Each cell keeps one coefficient fixed. Samples and running sums both travel from the first cell towards the last. A sample spends two register stages in each cell, while a running sum spends only one. The faster sums therefore overtake the samples, and every sum meets the samples of its window in the right order. No wire fans a sample out to all cells, and once the row is full every cell does a multiply-accumulate on each clock.

Samples arrive with a valid flag, one per clock at most. A run of consecutive valid cycles forms a burst. An idle cycle ends the burst, and no window is ever formed across it. A result leaves with its own valid flag only when all K samples of its window belong to one burst. The accumulators are sized so that no combination of inputs can overflow them.

Top module: `sconv_array`

## Requirements
- R1: A valid result equals the exact signed sum of c_j·x_{i+j} for j = 0..K-1. Coefficient index 0 multiplies the oldest sample of the window and index K-1 the newest. Samples and coefficients are DW-bit two's complement values.
- R2: Take the edge that captures the newest sample of a window as edge 1. The window's result is visible on res_data with res_valid high right after edge K.
- R3: The result width is 2·DW + clog2(K) bits, two's complement. All results stay exact, including every extreme case such as all samples and all coefficients at the most negative value (for K=4 and DW=8 this gives +65536).
- R4: A burst of n consecutive valid samples yields exactly max(0, n-K+1) results, one per clock and with no gaps. res_valid is low whenever no window has completed.
- R5: A cycle with smp_valid low ends a burst. No result ever combines samples from both sides of an idle cycle.
- R6: While rst_n is low and after its release, res_valid is low and every coefficient reads as zero. A burst streamed with no coefficient load therefore yields all-zero results.
- R7: A high coef_wr writes coef_val into the coefficient selected by coef_sel at the next rising edge. The other coefficients keep their values, and all of them hold until they are written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_sel | input | SW | Index of the coefficient to write (0 = oldest-sample tap) |
| coef_val | input | DW | Signed coefficient value |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DW | Signed sample |
| res_valid | output | 1 | A fully formed result is present |
| res_data | output | AW | Signed result, AW = 2·DW + clog2(K) |

## Verification
The bench builds the array with its defaults, K = 4 taps and 8-bit signed data. With these values a full window needs two skew stages in each of three hand-offs, and the 18-bit result holds the extreme products with exactly one bit to spare, which the all-most-negative case reaches. Four taps also let short bursts (three samples, fewer than K) be compared with longer ones. Gaps placed one cycle inside a burst land in the middle of in-flight windows. Long random runs with random coefficients check every cycle against a direct sum of the logged input history.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

   // Result width: full product plus growth for summing TAPS products.
   function automatic int acc_bits(input int dw, input int taps);
      return 2 * dw + $clog2(taps);
   endfunction

   // Width of the coefficient select field (at least one bit).
   function automatic int sel_bits(input int taps);
      return (taps > 1) ? $clog2(taps) : 1;
   endfunction

endpackage

// File: rtl/sconv_wbank.sv
module sconv_wbank #(
   parameter int TAPS = 4,
   parameter int DW   = 8,
   parameter int SW   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       coef_wr,
   input  logic [SW-1:0]              coef_sel,
   input  logic [DW-1:0]              coef_val,
   output logic [TAPS-1:0][DW-1:0]    taps_q
);

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            taps_q[t] <= '0;
         end else if (coef_wr && (coef_sel == SW'(t))) begin
            taps_q[t] <= coef_val;
         end
      end
   end

endmodule

// File: rtl/sconv_skew.sv
module sconv_skew #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] d_in,
   input  logic          v_in,
   output logic [DW-1:0] d_out,
   output logic          v_out
);

   // Two stages per cell: samples move at half the speed of sums.
   logic [DW-1:0] d_mid;
   logic          v_mid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_mid <= '0;
         v_mid <= 1'b0;
         d_out <= '0;
         v_out <= 1'b0;
      end else begin
         d_mid <= d_in;
         v_mid <= v_in;
         d_out <= d_mid;
         v_out <= v_mid;
      end
   end

endmodule

// File: rtl/sconv_mac.sv
module sconv_mac #(
   parameter int DW = 8,
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] coef,
   input  logic [DW-1:0] smp,
   input  logic          smp_ok,
   input  logic [AW-1:0] acc_in,
   input  logic          acc_ok_in,
   output logic [AW-1:0] acc_out,
   output logic          acc_ok_out
);

   logic signed [2*DW-1:0] prod;

   assign prod = $signed(coef) * $signed(smp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_out    <= '0;
         acc_ok_out <= 1'b0;
      end else begin
         acc_out    <= acc_in + AW'(prod);
         acc_ok_out <= acc_ok_in & smp_ok;
      end
   end

endmodule

// File: rtl/sconv_array.sv
module sconv_array #(
   parameter  int TAPS = 4,
   parameter  int DW   = 8,
   localparam int AW   = sconv_pkg::acc_bits(DW, TAPS),
   localparam int SW   = sconv_pkg::sel_bits(TAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          coef_wr,
   input  logic [SW-1:0] coef_sel,
   input  logic [DW-1:0] coef_val,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_data,
   output logic          res_valid,
   output logic [AW-1:0] res_data
);

   if (TAPS < 1) begin : g_bad_taps
      $error("sconv_array: TAPS must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("sconv_array: DW must be at least 2");
   end

   logic [TAPS-1:0][DW-1:0] taps_q;
   logic [TAPS-1:0][DW-1:0] xs;
   logic [TAPS-1:0]         xsv;
   logic [TAPS:0][AW-1:0]   ys;
   logic [TAPS:0]           ysv;

   sconv_wbank #(.TAPS(TAPS), .DW(DW), .SW(SW)) u_wbank (
      .clk      (clk),
      .rst_n    (rst_n),
      .coef_wr  (coef_wr),
      .coef_sel (coef_sel),
      .coef_val (coef_val),
      .taps_q   (taps_q)
   );

   // Sums start at zero and are always eligible; sample validity gates them.
   assign xs[0]  = smp_data;
   assign xsv[0] = smp_valid;
   assign ys[0]  = '0;
   assign ysv[0] = 1'b1;

   // Sums overtake samples, so the first cell meets the newest sample:
   // cell j holds coefficient TAPS-1-j.
   for (genvar j = 0; j < TAPS; j++) begin : g_cell
      sconv_mac #(.DW(DW), .AW(AW)) u_mac (
         .clk        (clk),
         .rst_n      (rst_n),
         .coef       (taps_q[TAPS-1-j]),
         .smp        (xs[j]),
         .smp_ok     (xsv[j]),
         .acc_in     (ys[j]),
         .acc_ok_in  (ysv[j]),
         .acc_out    (ys[j+1]),
         .acc_ok_out (ysv[j+1])
      );
      if (j < TAPS - 1) begin : g_fwd
         sconv_skew #(.DW(DW)) u_skew (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (xs[j]),
            .v_in  (xsv[j]),
            .d_out (xs[j+1]),
            .v_out (xsv[j+1])
         );
      end
   end

   assign res_data  = ys[TAPS];
   assign res_valid = ysv[TAPS];

endmodule

// File: rtl/sconv_array_chk.sv
module sconv_array_chk #(
   parameter int TAPS = 4,
   parameter int DW   = 8,
   parameter int AW   = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic          res_valid,
   input logic [AW-1:0] res_data
);

   localparam int     RW    = $clog2(TAPS + 1);
   localparam longint BOUND = longint'(TAPS) * (longint'(1) << (2 * DW - 2));

   logic [RW-1:0]   run_q;
   logic [RW-1:0]   since_q;
   logic            win_now;
   logic [TAPS-1:0] win_pipe;
   logic [TAPS-1:0] vhist;

   // A sample closes a window when TAPS-1 valid samples directly precede it.
   assign win_now = smp_valid && (run_q >= RW'(TAPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= '0;
         since_q  <= '0;
         win_pipe <= '0;
         vhist    <= '0;
      end else begin
         if (!smp_valid)               run_q <= '0;
         else if (run_q < RW'(TAPS))   run_q <= run_q + 1'b1;
         if (since_q < RW'(TAPS))      since_q <= since_q + 1'b1;
         win_pipe[0] <= win_now;
         vhist[0]    <= smp_valid;
         for (int i = 1; i < TAPS; i++) begin
            win_pipe[i] <= win_pipe[i-1];
            vhist[i]    <= vhist[i-1];
         end
      end
   end

   // R2 and R4: result flag appears exactly TAPS edges after a window closes.
   p_valid_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == win_pipe[TAPS-1]);

   p_sum_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (longint'($signed(res_data)) <= BOUND &&
                     longint'($signed(res_data)) >= -BOUND));

   p_gap_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !vhist[TAPS-1] |-> !res_valid);

   p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q < RW'(TAPS)) |-> !res_valid);

endmodule

bind sconv_array sconv_array_chk #(.TAPS(TAPS), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .res_valid (res_valid),
   .res_data  (res_data)
);

// File: tb/sconv_array_tb.sv
module sconv_array_tb;

   localparam int TAPS       = 4;
   localparam int DW         = 8;
   localparam int AW         = 2 * DW + $clog2(TAPS);
   localparam int SW         = (TAPS > 1) ? $clog2(TAPS) : 1;
   localparam int CLK_PERIOD = 10;
   localparam int HMAX       = 8192;

   logic          clk;
   logic          rst_n;
   logic          coef_wr;
   logic [SW-1:0] coef_sel;
   logic [DW-1:0] coef_val;
   logic          smp_valid;
   logic [DW-1:0] smp_data;
   logic          res_valid;
   logic [AW-1:0] res_data;

   sconv_array #(.TAPS(TAPS), .DW(DW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .coef_wr   (coef_wr),
      .coef_sel  (coef_sel),
      .coef_val  (coef_val),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

   int     n_chk, n_fail, ec, res_count, last_out_ec;
   bit     done;
   bit     hv [HMAX];
   longint hx [HMAX];
   longint wm [TAPS];
   string  vtag, ttag;

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic bit exp_valid(input int m);
      int base = m - 2 * TAPS + 2;
      if (base < 0) return 1'b0;
      for (int j = 0; j < TAPS; j++) if (!hv[base + j]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic longint exp_val(input int m);
      int base = m - 2 * TAPS + 2;
      longint s = 0;
      for (int j = 0; j < TAPS; j++) s += wm[j] * hx[base + j];
      return s;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, ec);
      end
   endtask

   task automatic check_out();
      int m = ec - 1;
      bit ev = exp_valid(m);
      chk(res_valid == ev, vtag, longint'(res_valid), longint'(ev));
      if (res_valid) begin
         res_count++;
         last_out_ec = m;
      end
      if (res_valid && ev)
         chk(longint'($signed(res_data)) == exp_val(m), ttag,
             longint'($signed(res_data)), exp_val(m));
   endtask

   // Drive at the falling edge, log at the rising edge, check at the next falling edge.
   task automatic step(input bit v, input longint s);
      smp_valid = v;
      smp_data  = DW'(s);
      @(posedge clk);
      hv[ec] = v;
      hx[ec] = s;
      ec++;
      @(negedge clk);
      check_out();
      smp_valid = 1'b0;
      coef_wr   = 1'b0;
   endtask

   task automatic flush();
      repeat (2 * TAPS) step(1'b0, 0);
   endtask

   task automatic load(input int idx, input longint val);
      coef_wr  = 1'b1;
      coef_sel = SW'(idx);
      coef_val = DW'(val);
      step(1'b0, 0);
      wm[idx] = val;
   endtask

   function automatic longint rnd_s();
      return longint'($urandom_range(255)) - 128;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4 watchdog expired actual=%0d expected=0", ec);
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      int L;
      seed_init = $urandom(32'd4242);
      n_chk = 0; n_fail = 0; ec = 0; res_count = 0; last_out_ec = -1; done = 1'b0;
      for (int j = 0; j < TAPS; j++) wm[j] = 0;
      rst_n = 1'b0; coef_wr = 1'b0; coef_sel = '0; coef_val = '0;
      smp_valid = 1'b0; smp_data = '0;
      vtag = "R4"; ttag = "R1";

      // R6: quiet during reset
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b0, "R6", longint'(res_valid), 0);
      rst_n = 1'b1;

      // R6: coefficients are zero after reset, so results are zero
      ttag = "R6";
      for (int i = 0; i < 7; i++) step(1'b1, rnd_s());
      flush();

      // R1 and R4: ramp burst with distinct coefficients
      ttag = "R1";
      for (int j = 0; j < TAPS; j++) load(j, j + 1);
      flush();
      res_count = 0;
      for (int i = 0; i < 10; i++) step(1'b1, i - 3);
      flush();
      chk(res_count == 10 - TAPS + 1, "R4", res_count, 10 - TAPS + 1);

      // R4: burst shorter than the window gives nothing
      res_count = 0;
      for (int i = 0; i < TAPS - 1; i++) step(1'b1, 9);
      flush();
      chk(res_count == 0, "R4", res_count, 0);

      // R5: an idle cycle splits bursts
      vtag = "R5";
      res_count = 0;
      for (int i = 0; i < 5; i++) step(1'b1, 11 * i - 20);
      step(1'b0, 0);
      for (int i = 0; i < 5; i++) step(1'b1, 50 - 7 * i);
      flush();
      chk(res_count == 2 * (5 - TAPS + 1), "R5", res_count, 2 * (5 - TAPS + 1));
      vtag = "R4";

      // R2: latency from the edge that captures the newest sample
      for (int i = 0; i < TAPS; i++) step(1'b1, 3 * i + 1);
      L = ec - 1;
      last_out_ec = -1;
      flush();
      chk(last_out_ec - L == TAPS - 1, "R2", last_out_ec - L, TAPS - 1);

      // R3: extreme values stay exact
      ttag = "R3";
      for (int j = 0; j < TAPS; j++) load(j, -128);
      flush();
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, -128);
      flush();
      for (int j = 0; j < TAPS; j++) load(j, 127);
      flush();
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, -128);
      flush();
      for (int j = 0; j < TAPS; j++) load(j, (j % 2) ? 127 : -128);
      flush();
      for (int i = 0; i < TAPS + 4; i++) step(1'b1, (i % 2) ? 127 : -128);
      flush();

      // R7: rewrite a single tap, the others hold
      ttag = "R7";
      for (int j = 0; j < TAPS; j++) load(j, 10 * j - 15);
      load(TAPS / 2, 5);
      flush();
      for (int i = 0; i < 12; i++) step(1'b1, rnd_s());
      flush();

      // R1: constrained random streams and coefficients
      ttag = "R1";
      for (int blk = 0; blk < 4; blk++) begin
         for (int j = 0; j < TAPS; j++) load(j, rnd_s());
         flush();
         for (int i = 0; i < 400; i++) step(($urandom_range(99) < 85), rnd_s());
         flush();
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule